// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block sequences a small processor core into and out of four low-power modes. The core raises a one-cycle sleep strobe when it executes its sleep instruction. That strobe takes effect only while the sleep-enable input is high. The 2-bit mode input is captured at entry. Afterwards the block drives separate clock enables for the core, the general I/O peripheral group, the ADC and the asynchronous timer. Which peripherals stay clocked depends on the captured mode.

While asleep, the block accepts only the wake sources that the captured mode allows. An accepted wake holds the core clock off for four further cycles. The block then gives a one-cycle resume pulse, and a flag with that pulse says whether an interrupt is to be serviced. A reset source seen during sleep or the halt returns the core at once to the running state, with a reboot pulse instead of a resume. On entry to the two lighter modes, the block can also issue a one-cycle automatic ADC start request.

Architectural state is never touched; only the clock enables change.

Top module: `slp_wake_ctl`

## Requirements
- R1: A sleep strobe puts the block to sleep only when it arrives in the running state with `se` = 1. A strobe with `se` = 0, or a strobe during sleep, halt or resume, has no effect.
- R2: The mode is encoded as 00 light idle, 01 ADC quiet, 10 deep off and 11 timer keep.
  - While asleep, `cpu_clk_en` = 0.
  - `io_clk_en` = 1 only in mode 00.
  - `adc_clk_en` = 1 in modes 00 and 01.
  - `async_clk_en` = 1 in every mode except 10.
  - Outside sleep, all three peripheral enables are 1.
- R3: The wake sources accepted in each mode are:
  - Mode 00: any of the wake inputs.
  - Mode 01: `wk_lvl`, `wk_addr`, `wk_adc` or `wk_t2`.
  - Mode 10: only `wk_lvl` or `wk_addr`.
  - Mode 11: `wk_lvl`, `wk_addr`, or `wk_t2` when `t2_async` = 1.
  - Any other wake input leaves the block asleep.
- R4: A wake accepted at a clock edge keeps `cpu_clk_en` low for exactly four more cycles. The next cycle gives `resume` = 1 for one cycle with `cpu_clk_en` = 1, and the block then returns to the running state.
- R5: `svc_irq` is 1 with `resume`, with one exception. It is 0 when the wake came in mode 01 from `wk_t2` alone with `t2_async` = 0.
- R6: `rst_src` seen at an edge during sleep or halt ends them. In the next cycle the block is running with all enables 1, `reboot` pulses for one cycle, and no `resume` follows.
- R7: Entry into mode 00 or 01 with `adc_en` = 1 gives a one-cycle `adc_start` pulse in the first sleep cycle. No other entry gives one.
- R8: The mode is captured at entry. Changes of `sm` during sleep do not alter the enables or the wake filter.
- R9: After reset the block is running, with all clock enables 1 and `resume`, `svc_irq`, `adc_start` and `reboot` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| se | input | 1 | Sleep enable |
| sm | input | 2 | Requested sleep mode |
| adc_en | input | 1 | ADC is enabled |
| t2_async | input | 1 | Timer 2 runs from its own clock |
| wk_lvl | input | 1 | External level interrupt request |
| wk_edge | input | 1 | External edge interrupt request |
| wk_addr | input | 1 | Two-wire address match |
| wk_adc | input | 1 | ADC conversion complete |
| wk_t2 | input | 1 | Timer 2 compare or overflow |
| wk_misc | input | 1 | Any other enabled peripheral interrupt |
| rst_src | input | 1 | External, watchdog or brown-out reset request |
| cpu_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | 1 | I/O peripheral group clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| async_clk_en | output | 1 | Asynchronous timer clock enable |
| adc_start | output | 1 | Automatic conversion start pulse |
| resume | output | 1 | Continue after the sleep instruction |
| svc_irq | output | 1 | Interrupt to be serviced at resume |
| reboot | output | 1 | Wake through reset |

## Verification
The bench targets the following mistakes:
- Edge and miscellaneous interrupts raised in modes 01 and 10. A wrong filter would wake early.
- A synchronous timer 2 wake in mode 01, where a design that always flags an interrupt would raise a spurious service.
- The halt counted one cycle short or long. This shifts the resume pulse.
- A reset during halt, where a faulty design would still emit `resume`.
- Changing `sm` in mid-sleep and issuing strobes with `se` low or during halt. These catch designs that read the live mode or accept stray strobes.

// File: rtl/slp_wake_ctl.sv
module slp_wake_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_stb,
  input  logic       se,
  input  logic [1:0] sm,
  input  logic       adc_en,
  input  logic       t2_async,
  input  logic       wk_lvl,
  input  logic       wk_edge,
  input  logic       wk_addr,
  input  logic       wk_adc,
  input  logic       wk_t2,
  input  logic       wk_misc,
  input  logic       rst_src,
  output logic       cpu_clk_en,
  output logic       io_clk_en,
  output logic       adc_clk_en,
  output logic       async_clk_en,
  output logic       adc_start,
  output logic       resume,
  output logic       svc_irq,
  output logic       reboot
);
  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_HALT, S_RESUME} st_t;

  st_t        st;
  logic [1:0] mode_q;
  logic [1:0] hcnt;
  logic       svc_q;
  logic       wake_ok;
  logic       t2_only;

  always_comb begin
    case (mode_q)
      2'b00:   wake_ok = wk_lvl | wk_edge | wk_addr | wk_adc | wk_t2 | wk_misc;
      2'b01:   wake_ok = wk_lvl | wk_addr | wk_adc | wk_t2;
      2'b10:   wake_ok = wk_lvl | wk_addr;
      default: wake_ok = wk_lvl | wk_addr | (wk_t2 & t2_async);
    endcase
  end

  assign t2_only = (mode_q == 2'b01) && wk_t2 && !t2_async && !(wk_lvl | wk_addr | wk_adc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      mode_q    <= 2'b00;
      hcnt      <= 2'd0;
      svc_q     <= 1'b0;
      adc_start <= 1'b0;
      reboot    <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      reboot    <= 1'b0;
      case (st)
        S_RUN: if (sleep_stb && se) begin
          st        <= S_SLEEP;
          mode_q    <= sm;
          adc_start <= adc_en && !sm[1];
        end
        S_SLEEP: if (rst_src) begin
          st     <= S_RUN;
          reboot <= 1'b1;
        end else if (wake_ok) begin
          st    <= S_HALT;
          hcnt  <= 2'd0;
          svc_q <= !t2_only;
        end
        S_HALT: if (rst_src) begin
          st     <= S_RUN;
          reboot <= 1'b1;
        end else begin
          hcnt <= hcnt + 2'd1;
          if (hcnt == 2'd3) st <= S_RESUME;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en   = (st == S_RUN) || (st == S_RESUME);
  assign io_clk_en    = (st != S_SLEEP) || (mode_q == 2'b00);
  assign adc_clk_en   = (st != S_SLEEP) || !mode_q[1];
  assign async_clk_en = (st != S_SLEEP) || (mode_q != 2'b10);
  assign resume       = (st == S_RESUME);
  assign svc_irq      = resume && svc_q;

  // R1
  se_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !resume && sleep_stb && !se) |=> cpu_clk_en);

  // R3
  deep_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && mode_q == 2'b10 && !wk_lvl && !wk_addr && !rst_src) |=> (st == S_SLEEP));

  // R4
  halt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!$past(cpu_clk_en, 1) && !$past(cpu_clk_en, 2) &&
                !$past(cpu_clk_en, 3) && !$past(cpu_clk_en, 4)));

  // R4
  resume_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (!resume && cpu_clk_en));

  // R5
  svc_with_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |-> resume);

  // R6
  reboot_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot |-> (cpu_clk_en && io_clk_en && !resume));

  // R7
  adc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (!cpu_clk_en && adc_clk_en && $past(cpu_clk_en)));
endmodule

// File: tb/slp_wake_ctl_bench.sv
module slp_wake_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic sleep_stb = 0, se = 0, adc_en = 0, t2_async = 0;
  logic [1:0] sm = 0;
  logic wk_lvl = 0, wk_edge = 0, wk_addr = 0, wk_adc = 0, wk_t2 = 0, wk_misc = 0, rst_src = 0;
  logic cpu_clk_en, io_clk_en, adc_clk_en, async_clk_en, adc_start, resume, svc_irq, reboot;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R9";

  slp_wake_ctl u_slp_wake_ctl (.*);

  always #5 clk = ~clk;

  // reference model: phase 0 run, 1 sleep, 2..5 halt, 6 resume
  int  ph = 0, e_mode = 0;
  bit  e_svc = 0, e_adcs = 0, e_rb = 0;

  function automatic bit accepts(int m);
    if (m == 0) return wk_lvl || wk_edge || wk_addr || wk_adc || wk_t2 || wk_misc;
    if (m == 1) return wk_lvl || wk_addr || wk_adc || wk_t2;
    if (m == 2) return wk_lvl || wk_addr;
    return wk_lvl || wk_addr || (wk_t2 && t2_async);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; e_mode = 0; e_svc = 0; e_adcs = 0; e_rb = 0;
    end else begin
      e_adcs = 0; e_rb = 0;
      if (ph == 0) begin
        if (sleep_stb && se) begin
          ph = 1; e_mode = int'(sm); e_adcs = adc_en && (sm < 2);
        end
      end else if (ph == 6) ph = 0;
      else if (rst_src) begin ph = 0; e_rb = 1; end
      else if (ph == 1) begin
        if (accepts(e_mode)) begin
          ph = 2;
          e_svc = !(e_mode == 1 && wk_t2 && !t2_async && !wk_lvl && !wk_addr && !wk_adc);
        end
      end else ph = ph + 1;
    end
  end

  task automatic cmp(string nm, logic a, bit e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", tag, nm, cyc, a, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    cmp("cpu_clk_en", cpu_clk_en, ph == 0 || ph == 6);
    cmp("io_clk_en", io_clk_en, ph != 1 || e_mode == 0);
    cmp("adc_clk_en", adc_clk_en, ph != 1 || e_mode < 2);
    cmp("async_clk_en", async_clk_en, ph != 1 || e_mode != 2);
    cmp("adc_start", adc_start, e_adcs);
    cmp("resume", resume, ph == 6);
    cmp("svc_irq", svc_irq, ph == 6 && e_svc);
    cmp("reboot", reboot, e_rb);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep(logic [1:0] m);
    sm = m; se = 1; sleep_stb = 1; step(1); sleep_stb = 0; se = 0;
  endtask

  initial begin
    step(2); rst_n = 1;
    tag = "R9"; step(2);

    tag = "R1"; sm = 2'b10; sleep_stb = 1; step(1); sleep_stb = 0; step(3);

    tag = "R7"; adc_en = 1; go_sleep(2'b00); step(2);
    tag = "R3"; wk_misc = 1; step(1); wk_misc = 0;
    tag = "R4"; step(7);

    tag = "R3"; go_sleep(2'b01); wk_edge = 1; wk_misc = 1; step(3); wk_edge = 0; wk_misc = 0;
    tag = "R5"; wk_t2 = 1; step(1); wk_t2 = 0;
    tag = "R1"; se = 1; sleep_stb = 1; step(1); sleep_stb = 0; se = 0; step(6);

    tag = "R2"; go_sleep(2'b10); step(2);
    tag = "R8"; sm = 2'b00; step(2);
    tag = "R3"; t2_async = 1; wk_t2 = 1; wk_adc = 1; wk_edge = 1; wk_misc = 1; step(3);
    wk_t2 = 0; wk_adc = 0; wk_edge = 0; wk_misc = 0;
    wk_addr = 1; step(1); wk_addr = 0; step(7);

    tag = "R5"; go_sleep(2'b11); step(2); wk_t2 = 1; step(1); wk_t2 = 0; step(7);

    tag = "R3"; t2_async = 0; adc_en = 0; go_sleep(2'b11); wk_t2 = 1; step(3); wk_t2 = 0;
    tag = "R6"; rst_src = 1; step(1); rst_src = 0; step(4);

    tag = "R6"; go_sleep(2'b01); wk_lvl = 1; wk_t2 = 1; step(1); wk_lvl = 0; wk_t2 = 0;
    step(2); rst_src = 1; step(1); rst_src = 0; step(6);

    tag = "R5"; adc_en = 1; go_sleep(2'b01); wk_t2 = 1; wk_adc = 1; step(1); wk_t2 = 0; wk_adc = 0; step(8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule